// File: doc/BRIEF.md
# Double-Buffered USB OUT Endpoint Receive Store

This block sits between the serial interface engine of a full-speed USB device and the processor. It stores the data stage of OUT transactions for one endpoint in two packet slots that are used alternately. The engine marks the start of a data packet and hands over bytes one per cycle. It then either commits the packet, once its checks pass, or aborts it on a CRC or bit-stuff error. The processor drains the oldest committed packet one byte per read strobe through a 32-bit data register.

Space is granted one whole packet at a time. While both slots hold committed packets, the block raises a NAK request, and the engine answers every OUT transaction with NAK. The request stays up until the processor has read the final byte of the packet at the head. Only at that point is a complete slot free again. A head byte count, a packet-ready flag and an optional per-packet interrupt pulse let the processor see how much to read.

Top module: `usb_out_pingpong`

## Requirements
- R1: After reset the data register reads 0x00000000 and `rx_nak`, `pkt_ready`, `irq` and `head_count` are all zero.
- R2: With two committed packets unread, `rx_nak` is 1. A packet started while `rx_nak` is 1 is refused, so its bytes and commit change no stored data and no count.
- R3: Once raised, `rx_nak` stays 1 through partial reads of the head packet. It falls only in the cycle after the processor reads that packet's last byte.
- R4: A `cpu_rd` strobe while a packet is ready places the next head byte in `cpu_rdata[7:0]` on the following clock edge, with bits 31:8 zero. Bytes come out in the order they were written.
- R5: Committed packets are drained in the order they were committed, and the two slots are filled alternately.
- R6: `head_count` gives the number of bytes in the packet at the head, from 1 to 64, and reads 0 when no packet is ready.
- R7: An aborted packet leaves no trace. Its slot stays free, and the next committed packet is the one read.
- R8: A `cpu_rd` strobe while no packet is ready loads 0 into the data register and moves no read pointer.
- R9: `pkt_ready` is 1 exactly while at least one committed packet is unread.
- R10: With `IRQ_ON_COMMIT` set, `irq` pulses high for one cycle after each accepted commit, and for nothing else.
- R11: Bytes past the 64th in one packet are dropped, and the stored count saturates at 64.
- R12: Committing a packet that holds no bytes consumes no slot and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sie_start | input | 1 | Start of an OUT data packet; the packet is taken only if `rx_nak` is 0 in this cycle |
| sie_wr_en | input | 1 | Byte strobe from the engine |
| sie_wr_data | input | 8 | Received byte |
| sie_commit | input | 1 | Packet received without error |
| sie_abort | input | 1 | Packet dropped on CRC or bit-stuff error |
| rx_nak | output | 1 | No whole slot free; the engine replies NAK |
| cpu_rd | input | 1 | Processor read strobe for the data register |
| cpu_rdata | output | 32 | Data register: head byte in bits 7:0, zero above |
| pkt_ready | output | 1 | At least one committed packet is waiting |
| head_count | output | 7 | Byte count of the head packet |
| irq | output | 1 | One-cycle pulse per committed packet |

## Verification
The assertions assume that each engine strobe lasts one cycle. They also assume that start, commit and abort never coincide, and that commits and aborts come only after a start. The processor read strobe may arrive at any time. The bench drives one engine strobe per cycle in exactly that order. Its directed scenarios cover refused starts, aborts, overlong packets, empty commits and idle reads, and each scenario checks the results it produces.

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong #(
  parameter int SLOT_BYTES    = 64,
  parameter bit IRQ_ON_COMMIT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sie_start,
  input  logic        sie_wr_en,
  input  logic [7:0]  sie_wr_data,
  input  logic        sie_commit,
  input  logic        sie_abort,
  output logic        rx_nak,
  input  logic        cpu_rd,
  output logic [31:0] cpu_rdata,
  output logic        pkt_ready,
  output logic [$clog2(SLOT_BYTES+1)-1:0] head_count,
  output logic        irq
);
  localparam int CW = $clog2(SLOT_BYTES + 1);
  localparam int IW = $clog2(2 * SLOT_BYTES);

  logic [7:0]    mem [0:2*SLOT_BYTES-1];
  logic [CW-1:0] cnt [0:1];
  logic [1:0]    full;
  logic          wr_sel, rd_sel, capturing;
  logic [CW-1:0] wr_ptr, rd_ptr;
  logic [IW-1:0] wr_idx, rd_idx;
  logic          wr_hit, rd_hit, rd_last, commit_ok;

  assign rx_nak     = full[wr_sel];
  assign pkt_ready  = full[rd_sel];
  assign head_count = pkt_ready ? cnt[rd_sel] : '0;

  assign wr_idx = wr_sel ? IW'(SLOT_BYTES) + IW'(wr_ptr) : IW'(wr_ptr);
  assign rd_idx = rd_sel ? IW'(SLOT_BYTES) + IW'(rd_ptr) : IW'(rd_ptr);

  assign wr_hit    = capturing && sie_wr_en && (wr_ptr < CW'(SLOT_BYTES));
  assign rd_hit    = cpu_rd && pkt_ready;
  assign rd_last   = rd_hit && (rd_ptr == cnt[rd_sel] - CW'(1));
  assign commit_ok = capturing && sie_commit && !sie_abort && !sie_start && (wr_ptr != '0);

  always_ff @(posedge clk)
    if (wr_hit) mem[wr_idx] <= sie_wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capturing <= 1'b0;
      wr_ptr    <= '0;
      wr_sel    <= 1'b0;
    end else begin
      if (sie_start) begin
        capturing <= !rx_nak;
        wr_ptr    <= '0;
      end else if (sie_abort || sie_commit) begin
        capturing <= 1'b0;
      end else if (wr_hit) begin
        wr_ptr <= wr_ptr + CW'(1);
      end
      if (commit_ok) wr_sel <= ~wr_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 2'b00;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      rd_sel    <= 1'b0;
      rd_ptr    <= '0;
      cpu_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= IRQ_ON_COMMIT && commit_ok;
      if (commit_ok) begin
        full[wr_sel] <= 1'b1;
        cnt[wr_sel]  <= wr_ptr;
      end
      if (rd_last) begin
        full[rd_sel] <= 1'b0;
        rd_sel       <= ~rd_sel;
        rd_ptr       <= '0;
      end else if (rd_hit) begin
        rd_ptr <= rd_ptr + CW'(1);
      end
      if (rd_hit)      cpu_rdata <= {24'd0, mem[rd_idx]};
      else if (cpu_rd) cpu_rdata <= '0;
    end
  end

  AST_NAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nak && !rd_last |=> rx_nak); // R3
  AST_REFUSED_START: assert property (@(posedge clk) disable iff (!rst_n)
    sie_start && rx_nak |=> !capturing); // R2
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !pkt_ready |=> cpu_rdata == 32'd0); // R8
  AST_READY_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> head_count != '0); // R12
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    head_count <= CW'(SLOT_BYTES)); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10
  AST_SLOT_SINGLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> !full[wr_sel]); // R5
endmodule

// File: tb/usb_out_pingpong_test.sv
module usb_out_pingpong_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sie_start = 0, sie_wr_en = 0, sie_commit = 0, sie_abort = 0, cpu_rd = 0;
  logic [7:0] sie_wr_data = 0;
  logic rx_nak, pkt_ready, irq;
  logic [31:0] cpu_rdata;
  logic [6:0] head_count;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_out_pingpong uut (.clk(clk), .rst_n(rst_n), .sie_start(sie_start), .sie_wr_en(sie_wr_en),
    .sie_wr_data(sie_wr_data), .sie_commit(sie_commit), .sie_abort(sie_abort), .rx_nak(rx_nak),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .pkt_ready(pkt_ready), .head_count(head_count), .irq(irq));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input logic [7:0] seed, input bit abort, output bit irq_seen);
    @(negedge clk) sie_start = 1;
    @(negedge clk) sie_start = 0;
    for (int i = 0; i < len; i++) begin
      sie_wr_en = 1; sie_wr_data = seed + 8'(i);
      @(negedge clk);
    end
    sie_wr_en = 0;
    if (abort) sie_abort = 1; else sie_commit = 1;
    @(negedge clk) sie_abort = 0; sie_commit = 0;
    irq_seen = irq;
    @(negedge clk);
    irq_seen = irq_seen | irq;
  endtask

  task automatic cpu_read(output logic [31:0] d);
    @(negedge clk) cpu_rd = 1;
    @(negedge clk) cpu_rd = 0;
    d = cpu_rdata;
  endtask

  task automatic drain_check(input int len, input logic [7:0] seed, input string req);
    logic [31:0] d;
    for (int i = 0; i < len; i++) begin
      cpu_read(d);
      check(d == {24'd0, seed + 8'(i)}, req, d, {24'd0, seed + 8'(i)});
    end
  endtask

  task automatic t_reset();
    check(cpu_rdata == 0, "R1", cpu_rdata, 0);
    check({rx_nak, pkt_ready, irq} == 0, "R1", {rx_nak, pkt_ready, irq}, 0);
    check(head_count == 0, "R1", head_count, 0);
  endtask

  task automatic t_single();
    bit q;
    send_pkt(5, 8'h10, 0, q);
    check(q, "R10", q, 1);
    check(pkt_ready, "R9", pkt_ready, 1);
    check(head_count == 5, "R6", head_count, 5);
    drain_check(5, 8'h10, "R4");
    check(!pkt_ready, "R9", pkt_ready, 0);
    check(head_count == 0, "R6", head_count, 0);
  endtask

  task automatic t_two_full();
    bit q; logic [31:0] d;
    send_pkt(3, 8'h20, 0, q);
    check(!rx_nak, "R2", rx_nak, 0);
    send_pkt(4, 8'h40, 0, q);
    check(rx_nak, "R2", rx_nak, 1);
    send_pkt(2, 8'h80, 0, q);
    check(!q, "R2", q, 0);
    check(head_count == 3, "R2", head_count, 3);
    drain_check(2, 8'h20, "R4");
    check(rx_nak, "R3", rx_nak, 1);
    cpu_read(d);
    check(d == 32'h22, "R3", d, 32'h22);
    check(!rx_nak, "R3", rx_nak, 0);
    check(head_count == 4, "R5", head_count, 4);
    drain_check(4, 8'h40, "R5");
    check(!pkt_ready, "R2", pkt_ready, 0);
  endtask

  task automatic t_alternate();
    bit q;
    send_pkt(2, 8'hA0, 0, q);
    drain_check(2, 8'hA0, "R5");
    send_pkt(3, 8'hB0, 0, q);
    send_pkt(1, 8'hC0, 0, q);
    check(head_count == 3, "R5", head_count, 3);
    drain_check(3, 8'hB0, "R5");
    check(head_count == 1, "R5", head_count, 1);
    drain_check(1, 8'hC0, "R5");
  endtask

  task automatic t_abort();
    bit q;
    send_pkt(6, 8'h55, 1, q);
    check(!pkt_ready && !q, "R7", {pkt_ready, q}, 0);
    send_pkt(2, 8'h66, 0, q);
    check(head_count == 2, "R7", head_count, 2);
    drain_check(2, 8'h66, "R7");
  endtask

  task automatic t_idle_read();
    bit q; logic [31:0] d;
    cpu_read(d);
    check(d == 0, "R8", d, 0);
    send_pkt(3, 8'h70, 0, q);
    drain_check(1, 8'h70, "R8");
    drain_check(2, 8'h71, "R8");
    cpu_read(d);
    check(d == 0, "R8", d, 0);
  endtask

  task automatic t_overflow();
    bit q;
    send_pkt(70, 8'h00, 0, q);
    check(head_count == 64, "R11", head_count, 64);
    drain_check(64, 8'h00, "R11");
    check(!pkt_ready, "R11", pkt_ready, 0);
  endtask

  task automatic t_empty();
    bit q;
    send_pkt(0, 8'h00, 0, q);
    check(!pkt_ready && !q, "R12", {pkt_ready, q}, 0);
    check(!rx_nak, "R12", rx_nak, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_two_full();
    t_alternate();
    t_abort();
    t_idle_read();
    t_overflow();
    t_empty();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule